// File: doc/BRIEF.md
# Order-Tolerant Peripheral Bus Cycle Qualifier

This block takes the control lines of an asynchronous, microprocessor-style host bus and turns them into clean single-cycle events in the system clock domain. The lines are an active-low chip select, an active-low read strobe and an active-low write strobe. A peripheral register file uses those events. A read produces a start pulse when it opens and an end pulse when it closes, so that registers with side effects, such as a FIFO pop or a status clear, change once per access. A write produces one commit pulse when the access closes. The commit pulse comes with the address and data that were held on the bus during the access.

The host may drive chip select and a strobe in either order, and may release them in either order. An access is the interval in which both are active. It opens when the later of the two becomes active and closes when the earlier of the two goes inactive. Each bus line passes through a synchronizer before the lines are combined. The combined level is then edge-detected. If chip select is active with both strobes at the same time, the block reports a bus error. It then performs neither access, and it stays quiet until the host leaves the bus.

Top module: `bus_cycle_qualifier`

## Requirements
- R1: While reset is held, and right after it, every pulse output is 0, and `wr_addr` and `wr_data` are 0.
- R2: `rd_start` pulses high for exactly one clock each time chip select and read strobe become active together, whichever of the two was asserted first.
- R3: `rd_end` pulses high for exactly one clock when the first of chip select and read strobe goes inactive, whichever is released first, and only after an `rd_start` for the same access.
- R4: `wr_commit` pulses high for exactly one clock when the first of chip select and write strobe goes inactive, whichever is released first, and it does not pulse when the write opens.
- R5: `wr_addr` and `wr_data` show the `addr` and `wdata` that were on the bus while the write was active, even if the bus changes one clock after the release, and they change only in the cycle where `wr_commit` is 1.
- R6: When chip select and both strobes are active at once, `bus_err` pulses for one clock, and that access produces no `rd_end` and no `wr_commit`. No new `rd_start` follows until chip select is inactive or both strobes are inactive.
- R7: A strobe without chip select, or chip select without a strobe, produces no pulse on any output.
- R8: `rd_start` is high in the cycle that follows the (SYNC_STAGES+1)-th rising clock edge after the input change that opened the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| addr | input | ADDR_W | Register address from the host |
| wdata | input | DATA_W | Write data from the host |
| rd_start | output | 1 | One-clock pulse when a read opens |
| rd_end | output | 1 | One-clock pulse when a read closes |
| wr_commit | output | 1 | One-clock pulse when a write closes and commits |
| wr_addr | output | ADDR_W | Address of the last committed write |
| wr_data | output | DATA_W | Data of the last committed write |
| bus_err | output | 1 | One-clock pulse when both strobes are active with chip select |

## Verification
The hardest case to reach is a read that turns into a conflict partway through. The read must already have produced its start pulse. The write strobe then arrives, and the read strobe stays asserted after the write strobe is withdrawn. The design must then stay silent and emit no end pulse. The bench reaches this case with a dedicated driver sequence that walks the lines through these steps one at a time, with several clocks between steps. The scoreboard expects only the start pulse and the error pulse from that sequence. A normal read then follows, which shows that the block recovers once the host leaves the bus. The write sequences change the address and data one clock after the release. This exposes any capture that is not aligned with the synchronized strobe.

// File: rtl/bus_cycle_qualifier.sv
module bus_cycle_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_start,
  output logic              rd_end,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              bus_err
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic [SYNC_STAGES-1:0] cs_sh, rd_sh, wr_sh;
  logic [BUS_W-1:0]       bus_dly [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '0;
      rd_sh <= '0;
      wr_sh <= '0;
    end else begin
      cs_sh <= {cs_sh[SYNC_STAGES-2:0], ~cs_n};
      rd_sh <= {rd_sh[SYNC_STAGES-2:0], ~rd_n};
      wr_sh <= {wr_sh[SYNC_STAGES-2:0], ~wr_n};
    end
  end

  // Bus contents delayed to line up with the synchronized strobes.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bus_dly[g] <= '0;
        else if (g == 0)
          bus_dly[g] <= {addr, wdata};
        else
          bus_dly[g] <= bus_dly[g-1];
      end
    end
  endgenerate

  wire cs_a = cs_sh[SYNC_STAGES-1];
  wire rd_a = rd_sh[SYNC_STAGES-1];
  wire wr_a = wr_sh[SYNC_STAGES-1];

  logic rd_q, wr_q, abort_q;
  logic [BUS_W-1:0] hold_q;

  wire on_bus   = cs_a & (rd_a | wr_a);
  wire clash    = cs_a & rd_a & wr_a;
  wire abort_d  = clash | (abort_q & on_bus);
  wire rd_lvl   = cs_a & rd_a & ~abort_d;
  wire wr_lvl   = cs_a & wr_a & ~abort_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      abort_q   <= 1'b0;
      hold_q    <= '0;
      rd_start  <= 1'b0;
      rd_end    <= 1'b0;
      wr_commit <= 1'b0;
      bus_err   <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      rd_q      <= rd_lvl;
      wr_q      <= wr_lvl;
      abort_q   <= abort_d;
      rd_start  <= rd_lvl & ~rd_q;
      rd_end    <= rd_q & ~rd_lvl & ~abort_d;
      wr_commit <= wr_q & ~wr_lvl & ~abort_d;
      bus_err   <= abort_d & ~abort_q;
      if (wr_lvl)
        hold_q <= bus_dly[SYNC_STAGES-1];
      if (wr_q & ~wr_lvl & ~abort_d)
        {wr_addr, wr_data} <= hold_q;
    end
  end

endmodule

// File: rtl/bus_cycle_qualifier_chk.sv
module bus_cycle_qualifier_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_start,
  input logic              rd_end,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              bus_err
);

  logic read_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          read_open <= 1'b0;
    else if (rd_start)   read_open <= 1'b1;
    else if (rd_end | bus_err) read_open <= 1'b0;
  end

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!rd_start && !rd_end && !wr_commit && !bus_err);
    end
  end

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

  a_r3_end_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |-> read_open);

  a_r4_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |-> ($stable(wr_addr) && $stable(wr_data)));

  a_r6_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!wr_commit && !rd_end));

  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);

endmodule

bind bus_cycle_qualifier bus_cycle_qualifier_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_end(rd_end),
  .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data), .bus_err(bus_err)
);

// File: tb/test_bus_cycle_qualifier.sv
`timescale 1ns/1ps
module test_bus_cycle_qualifier;
  localparam int SYNC_STAGES = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam logic [1:0] K_RS = 2'd0, K_RE = 2'd1, K_WC = 2'd2, K_ER = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic rd_start, rd_end, wr_commit, bus_err;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  int checks = 0, errors = 0, cyc = 0, last_rs = 0;
  logic [ADDR_W+DATA_W+1:0] expq [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_cycle_qualifier #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus_cycle_qualifier (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rd_start(rd_start), .rd_end(rd_end),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data), .bus_err(bus_err));

  function automatic string req_of(logic [1:0] k);
    case (k)
      K_RS: return "R2";
      K_RE: return "R3";
      K_WC: return "R4/R5";
      default: return "R6";
    endcase
  endfunction

  task automatic observe(logic [1:0] k, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    logic [ADDR_W+DATA_W+1:0] got, exp;
    got = {k, a, d};
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL R7 unexpected event %h, expected none", got);
    end else begin
      exp = expq.pop_front();
      if (got !== exp) begin
        errors++;
        $display("FAIL %s event %h expected %h", req_of(exp[ADDR_W+DATA_W+1 -: 2]), got, exp);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_commit) observe(K_WC, wr_addr, wr_data);
      if (rd_end)    observe(K_RE, '0, '0);
      if (bus_err)   observe(K_ER, '0, '0);
      if (rd_start) begin
        last_rs = cyc;
        observe(K_RS, '0, '0);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [1:0] k, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    expq.push_back({k, a, d});
  endtask

  task automatic bus_read(bit cs_first, bit cs_last, bit check_lat);
    int t0;
    @(negedge clk);
    if (cs_first) cs_n = 1'b0; else rd_n = 1'b0;
    idle(5);
    if (cs_first) rd_n = 1'b0; else cs_n = 1'b0;
    t0 = cyc;
    push(K_RS, '0, '0);
    idle(6);
    if (check_lat) begin
      checks++;
      if (last_rs - t0 != SYNC_STAGES + 1) begin
        errors++;
        $display("FAIL R8 latency %0d expected %0d", last_rs - t0, SYNC_STAGES + 1);
      end
    end
    if (cs_last) rd_n = 1'b1; else cs_n = 1'b1;
    push(K_RE, '0, '0);
    idle(5);
    cs_n = 1'b1; rd_n = 1'b1;
    idle(6);
  endtask

  task automatic bus_write(bit cs_first, bit cs_last, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (cs_first) cs_n = 1'b0; else wr_n = 1'b0;
    idle(4);
    if (cs_first) wr_n = 1'b0; else cs_n = 1'b0;
    idle(6);
    if (cs_last) wr_n = 1'b1; else cs_n = 1'b1;
    push(K_WC, a, d);
    idle(1);
    addr = ~a; wdata = ~d;
    idle(4);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(6);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    checks++;
    if ({rd_start, rd_end, wr_commit, bus_err, wr_addr, wr_data} !== '0) begin
      errors++;
      $display("FAIL R1 outputs %h expected 0", {rd_start, rd_end, wr_commit, bus_err, wr_addr, wr_data});
    end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if ({rd_start, rd_end, wr_commit, bus_err, wr_addr, wr_data} !== '0) begin
      errors++;
      $display("FAIL R1 after release %h expected 0", {rd_start, rd_end, wr_commit, bus_err, wr_addr, wr_data});
    end

    // R2 R3 R8: all four assert/release orders
    bus_read(1'b1, 1'b1, 1'b1);
    bus_read(1'b0, 1'b1, 1'b0);
    bus_read(1'b1, 1'b0, 1'b0);
    bus_read(1'b0, 1'b0, 1'b0);

    // R4 R5: all four orders, data changing after release
    bus_write(1'b1, 1'b1, 3'd5, 8'hA7);
    bus_write(1'b0, 1'b1, 3'd2, 8'h3C);
    bus_write(1'b1, 1'b0, 3'd7, 8'h01);
    bus_write(1'b0, 1'b0, 3'd0, 8'hF0);

    // R7: strobes without chip select, chip select alone
    rd_n = 1'b0; idle(6); rd_n = 1'b1; idle(2);
    wr_n = 1'b0; idle(6); wr_n = 1'b1; idle(2);
    cs_n = 1'b0; idle(8); cs_n = 1'b1; idle(6);

    // R6: read interrupted by a write strobe, read stays after the write leaves
    cs_n = 1'b0; rd_n = 1'b0;
    push(K_RS, '0, '0);
    idle(6);
    wr_n = 1'b0;
    push(K_ER, '0, '0);
    idle(6);
    wr_n = 1'b1;
    idle(8);
    rd_n = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(6);

    // R6: both strobes together under chip select
    addr = 3'd4; wdata = 8'h55;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    push(K_ER, '0, '0);
    idle(6);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    idle(6);

    // recovery after the conflicts
    bus_read(1'b1, 1'b1, 1'b0);
    bus_write(1'b1, 1'b1, 3'd6, 8'h9E);
    idle(10);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2/R3/R4/R6 missing %0d events expected 0", expq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule